// File: doc/BRIEF.md
# Register-Mapped Signed Integer Divider

This block is a signed integer divider that a processor drives as a set of 32-bit registers on a simple word bus. Software writes a mode into the control word and then loads a 64-bit dividend and a 64-bit divisor as pairs of 32-bit halves, low half at the lower address. Every write to the control word or to an operand word starts a fresh division on the current register contents. The control word shows a busy bit while a division is running. Once that bit drops, the 64-bit quotient and remainder words hold the new results.

A two-bit mode picks the operand widths: 32 by 32, 64 by 32 or 64 by 64 bits, all signed. The datapath works on magnitudes and produces one quotient bit per clock, so every division takes the same number of cycles. Two cases have defined results and raise an error bit: a zero divisor, and the most negative 64-bit dividend divided by minus one. The error bit stays set until a division completes without either condition.

Top module: `sdiv_mmio`

## Requirements
- R1: Control bits [1:0] (byte offset 0x00) select the mode. 0 sign-extends both dividend and divisor from their low 32 bits. 1 and 3 use the full 64-bit dividend and sign-extend the divisor from its low 32 bits. 2 uses both full 64-bit operands.
- R2: Away from the special cases, the quotient is the signed quotient truncated toward zero. The remainder takes the sign of the dividend, so quotient times divisor plus remainder equals the dividend.
- R3: When the divisor is zero after mode extension, the remainder becomes the extended dividend. The quotient becomes 1 if that dividend is negative and 0 otherwise, and control bit 14 (error) is set.
- R4: When the extended dividend is 0x8000_0000_0000_0000 and the extended divisor is -1, the quotient becomes the dividend unchanged, the remainder keeps its previous value, and the error bit is set.
- R5: A division that hits neither special case clears the error bit when it completes.
- R6: A write with at least one byte enable to the control word or to any operand word sets busy (control bit 15) at that clock edge. Exactly 66 edges later (OPW+2) the results are written and busy clears. The latency is the same for every case.
- R7: The quotient and remainder words keep their previous values for the whole time busy is set.
- R8: A start write while busy abandons the running division and begins again with the current registers. The latency counts from the latest write, and the abandoned division writes no results.
- R9: Byte enable k controls bits [8k+7:8k] of the addressed word. Lanes whose enable is low keep their value.
- R10: Writes to the result words, to unused words, with misaligned addresses or with no byte enable change no register and start nothing.
- R11: Word map: 0x00 control, 0x08/0x0C dividend low/high, 0x10/0x14 divisor low/high, 0x18/0x1C quotient low/high, 0x20/0x24 remainder low/high. Read data is registered on the edge where the read request is high. Unused words read zero, and control bits other than 15, 14 and 1:0 read zero.
- R12: After reset all registers read zero and busy is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the accessed word |
| bus_wr | input | 1 | Write request for this cycle |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read request for this cycle |
| bus_rdata | output | 32 | Registered read data |

## Verification
The engine's state is not visible outside the block, so a fault inside it reaches the ports only through a read. A wrong sign flag, a magnitude slip or a misclassified special case shows up as a wrong quotient, remainder or error bit in the first read after busy drops, which is 66 cycles after the last start write. A counter that steps too far or too little moves the busy fall away from that cycle, and the busy read on exactly that cycle catches it. Results that change early, or starts that are lost, show up in reads made while the division is still running.

// File: rtl/sdiv_mmio_pkg.sv
package sdiv_mmio_pkg;
  localparam int OPW   = 64;
  localparam int BUSW  = 32;
  localparam int BYTES = BUSW / 8;

  typedef logic [OPW-1:0]  op_t;
  typedef logic [BUSW-1:0] word_t;

  typedef enum logic [1:0] {ENG_IDLE, ENG_LOAD, ENG_RUN, ENG_DONE} eng_state_t;

  localparam logic [1:0] MODE_NARROW = 2'd0;
  localparam logic [1:0] MODE_WIDE   = 2'd2;

  // word indices (byte offset / 4)
  localparam int W_CTL = 0;
  localparam int W_NUM = 2;
  localparam int W_DEN = 4;
  localparam int W_QUO = 6;
  localparam int W_REM = 8;

  localparam int CTL_ERR  = 14;
  localparam int CTL_BUSY = 15;

  localparam op_t OP_MIN = {1'b1, {(OPW-1){1'b0}}};

  typedef struct packed {
    op_t part;
    op_t acc;
  } step_t;

  function automatic op_t sext_half(word_t w);
    return {{(OPW-BUSW){w[BUSW-1]}}, w};
  endfunction

  function automatic op_t fit_num(logic [1:0] mode, op_t raw);
    return (mode == MODE_NARROW) ? sext_half(raw[BUSW-1:0]) : raw;
  endfunction

  function automatic op_t fit_den(logic [1:0] mode, op_t raw);
    return (mode == MODE_WIDE) ? raw : sext_half(raw[BUSW-1:0]);
  endfunction

  function automatic op_t negate(op_t v);
    return ~v + op_t'(1);
  endfunction

  function automatic op_t magnitude(op_t v);
    return v[OPW-1] ? negate(v) : v;
  endfunction

  function automatic word_t merge_lanes(word_t old, word_t wdata, logic [BYTES-1:0] be);
    word_t res;
    res = old;
    for (int b = 0; b < BYTES; b++) begin
      if (be[b]) res[b*8 +: 8] = wdata[b*8 +: 8];
    end
    return res;
  endfunction

  // one restoring step: shift the next dividend bit in, subtract when it fits
  function automatic step_t div_step(op_t part, op_t acc, op_t dvs);
    logic [OPW:0] sh;
    step_t        r;
    sh  = {part, acc[OPW-1]};
    r.acc = {acc[OPW-2:0], 1'b0};
    if (sh >= {1'b0, dvs}) begin
      sh       = sh - {1'b0, dvs};
      r.acc[0] = 1'b1;
    end
    r.part = sh[OPW-1:0];
    return r;
  endfunction
endpackage

// File: rtl/sdiv_mmio_regs.sv
module sdiv_mmio_regs
  import sdiv_mmio_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic             bus_wr,
  input  logic [BYTES-1:0] bus_be,
  input  word_t            bus_wdata,
  input  logic             bus_rd,
  output word_t            bus_rdata,
  input  logic             busy,
  input  logic             commit,
  input  logic             rem_en,
  input  logic             err_in,
  input  op_t              quo_in,
  input  op_t              rem_in,
  output logic             start,
  output logic [1:0]       mode_q,
  output op_t              num_q,
  output op_t              den_q,
  output op_t              quo_q,
  output op_t              rem_q,
  output logic             err_q
);
  localparam int IW = ADDR_W - 2;
  localparam logic [IW-1:0] A_CTL    = IW'(W_CTL);
  localparam logic [IW-1:0] A_NUM_LO = IW'(W_NUM);
  localparam logic [IW-1:0] A_NUM_HI = IW'(W_NUM + 1);
  localparam logic [IW-1:0] A_DEN_LO = IW'(W_DEN);
  localparam logic [IW-1:0] A_DEN_HI = IW'(W_DEN + 1);
  localparam logic [IW-1:0] A_QUO_LO = IW'(W_QUO);
  localparam logic [IW-1:0] A_QUO_HI = IW'(W_QUO + 1);
  localparam logic [IW-1:0] A_REM_LO = IW'(W_REM);
  localparam logic [IW-1:0] A_REM_HI = IW'(W_REM + 1);

  logic [IW-1:0] widx;
  logic          aligned;
  logic          wr_ok;
  logic          hit_start;
  word_t         rd_mux;
  word_t         ctl_view;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_ok   = bus_wr && aligned && (|bus_be);

  always_comb begin
    case (widx)
      A_CTL, A_NUM_LO, A_NUM_HI, A_DEN_LO, A_DEN_HI: hit_start = 1'b1;
      default:                                       hit_start = 1'b0;
    endcase
  end

  assign start = wr_ok && hit_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      num_q  <= '0;
      den_q  <= '0;
    end else if (wr_ok) begin
      case (widx)
        A_CTL:    if (bus_be[0]) mode_q <= bus_wdata[1:0];
        A_NUM_LO: num_q[BUSW-1:0]   <= merge_lanes(num_q[BUSW-1:0],   bus_wdata, bus_be);
        A_NUM_HI: num_q[OPW-1:BUSW] <= merge_lanes(num_q[OPW-1:BUSW], bus_wdata, bus_be);
        A_DEN_LO: den_q[BUSW-1:0]   <= merge_lanes(den_q[BUSW-1:0],   bus_wdata, bus_be);
        A_DEN_HI: den_q[OPW-1:BUSW] <= merge_lanes(den_q[OPW-1:BUSW], bus_wdata, bus_be);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      err_q <= 1'b0;
    end else if (commit) begin
      quo_q <= quo_in;
      if (rem_en) rem_q <= rem_in;
      err_q <= err_in;
    end
  end

  always_comb begin
    ctl_view           = '0;
    ctl_view[1:0]      = mode_q;
    ctl_view[CTL_ERR]  = err_q;
    ctl_view[CTL_BUSY] = busy;
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (widx)
        A_CTL:    rd_mux = ctl_view;
        A_NUM_LO: rd_mux = num_q[BUSW-1:0];
        A_NUM_HI: rd_mux = num_q[OPW-1:BUSW];
        A_DEN_LO: rd_mux = den_q[BUSW-1:0];
        A_DEN_HI: rd_mux = den_q[OPW-1:BUSW];
        A_QUO_LO: rd_mux = quo_q[BUSW-1:0];
        A_QUO_HI: rd_mux = quo_q[OPW-1:BUSW];
        A_REM_LO: rd_mux = rem_q[BUSW-1:0];
        A_REM_HI: rd_mux = rem_q[OPW-1:BUSW];
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/sdiv_mmio_engine.sv
module sdiv_mmio_engine
  import sdiv_mmio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] mode,
  input  op_t        num_raw,
  input  op_t        den_raw,
  output logic       busy,
  output logic       commit,
  output logic       case_zero,
  output logic       case_ovf,
  output logic       rem_en,
  output logic       err_out,
  output op_t        quo_out,
  output op_t        rem_out
);
  localparam int CW = $clog2(OPW);
  localparam logic [CW-1:0] CNT_LAST = CW'(OPW - 1);

  eng_state_t    state;
  logic [CW-1:0] cnt;
  op_t           part;
  op_t           acc;
  op_t           dvs;
  op_t           keep;
  logic          neg_q;
  logic          neg_r;

  op_t   en_w;
  op_t   ed_w;
  step_t nxt;

  assign en_w = fit_num(mode, num_raw);
  assign ed_w = fit_den(mode, den_raw);
  assign nxt  = div_step(part, acc, dvs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ENG_IDLE;
      cnt       <= '0;
      part      <= '0;
      acc       <= '0;
      dvs       <= '0;
      keep      <= '0;
      neg_q     <= 1'b0;
      neg_r     <= 1'b0;
      case_zero <= 1'b0;
      case_ovf  <= 1'b0;
    end else if (start) begin
      state <= ENG_LOAD;
    end else begin
      case (state)
        ENG_LOAD: begin
          keep      <= en_w;
          case_zero <= (ed_w == '0);
          case_ovf  <= (en_w == OP_MIN) && (ed_w == '1);
          neg_q     <= en_w[OPW-1] ^ ed_w[OPW-1];
          neg_r     <= en_w[OPW-1];
          acc       <= magnitude(en_w);
          dvs       <= magnitude(ed_w);
          part      <= '0;
          cnt       <= '0;
          state     <= ENG_RUN;
        end
        ENG_RUN: begin
          part <= nxt.part;
          acc  <= nxt.acc;
          cnt  <= cnt + CW'(1);
          if (cnt == CNT_LAST) state <= ENG_DONE;
        end
        ENG_DONE: state <= ENG_IDLE;
        default:  state <= ENG_IDLE;
      endcase
    end
  end

  assign busy    = (state != ENG_IDLE);
  assign commit  = (state == ENG_DONE) && !start;
  assign rem_en  = !case_ovf;
  assign err_out = case_zero || case_ovf;

  always_comb begin
    if (case_zero)     quo_out = neg_r ? op_t'(1) : '0;
    else if (case_ovf) quo_out = keep;
    else if (neg_q)    quo_out = negate(acc);
    else               quo_out = acc;
  end

  always_comb begin
    if (case_zero)  rem_out = keep;
    else if (neg_r) rem_out = negate(part);
    else            rem_out = part;
  end
endmodule

// File: rtl/sdiv_mmio.sv
module sdiv_mmio
  import sdiv_mmio_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata
);
  logic       start;
  logic       busy;
  logic       commit;
  logic       case_zero;
  logic       case_ovf;
  logic       rem_en;
  logic       err_next;
  logic       err_q;
  logic [1:0] mode_q;
  op_t        num_q;
  op_t        den_q;
  op_t        quo_q;
  op_t        rem_q;
  op_t        quo_next;
  op_t        rem_next;

  sdiv_mmio_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .commit    (commit),
    .rem_en    (rem_en),
    .err_in    (err_next),
    .quo_in    (quo_next),
    .rem_in    (rem_next),
    .start     (start),
    .mode_q    (mode_q),
    .num_q     (num_q),
    .den_q     (den_q),
    .quo_q     (quo_q),
    .rem_q     (rem_q),
    .err_q     (err_q)
  );

  sdiv_mmio_engine u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode_q),
    .num_raw   (num_q),
    .den_raw   (den_q),
    .busy      (busy),
    .commit    (commit),
    .case_zero (case_zero),
    .case_ovf  (case_ovf),
    .rem_en    (rem_en),
    .err_out   (err_next),
    .quo_out   (quo_next),
    .rem_out   (rem_next)
  );
endmodule

// File: rtl/sdiv_mmio_chk.sv
module sdiv_mmio_chk
  import sdiv_mmio_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              start,
  input logic              busy,
  input logic              commit,
  input logic              case_zero,
  input logic              case_ovf,
  input logic              err_q,
  input op_t               quo_q,
  input op_t               rem_q
);
  localparam int SW = $clog2(OPW + 4);
  logic [SW-1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       since <= '0;
    else if (start)                   since <= '0;
    else if (busy && since != '1)     since <= since + SW'(1);
  end

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> busy);
  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n) commit |-> since == SW'(OPW + 1));
  // R6
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) commit |=> !busy);
  // R7
  quo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !commit |=> $stable(quo_q));
  // R7
  rem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !commit |=> $stable(rem_q));
  // R3
  zero_err_chk: assert property (@(posedge clk) disable iff (!rst_n) (commit && case_zero) |=> err_q);
  // R4
  ovf_rem_chk: assert property (@(posedge clk) disable iff (!rst_n) (commit && case_ovf) |=> ($stable(rem_q) && err_q));
  // R5
  clean_chk: assert property (@(posedge clk) disable iff (!rst_n) (commit && !case_zero && !case_ovf) |=> !err_q);
  // R10
  ro_nostart_chk: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && bus_addr >= ADDR_W'(W_QUO * 4)) |-> !start);
endmodule

bind sdiv_mmio sdiv_mmio_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .start     (start),
  .busy      (busy),
  .commit    (commit),
  .case_zero (case_zero),
  .case_ovf  (case_ovf),
  .err_q     (err_q),
  .quo_q     (quo_q),
  .rem_q     (rem_q)
);

// File: tb/sdiv_mmio_bench.sv
module sdiv_mmio_bench;
  localparam int ADDR_W = 6;
  localparam int LAT    = 66;
  localparam int I_CTL = 0, I_NUM = 2, I_DEN = 4, I_QUO = 6, I_REM = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_wr;
  logic [3:0]        bus_be;
  logic [31:0]       bus_wdata;
  logic              bus_rd;
  logic [31:0]       bus_rdata;

  int          n_chk  = 0;
  int          n_fail = 0;
  logic [63:0] prev_rem = '0;

  sdiv_mmio #(.ADDR_W(ADDR_W)) u_sdiv_mmio (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input int idx, input logic [31:0] d, input logic [3:0] be);
    bus_addr = ADDR_W'(idx * 4); bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic bus_read(input int idx, output logic [31:0] d);
    bus_addr = ADDR_W'(idx * 4); bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic read64(input int idx, output logic [63:0] v);
    logic [31:0] lo, hi;
    bus_read(idx, lo);
    bus_read(idx + 1, hi);
    v = {hi, lo};
  endtask

  task automatic model(input logic [1:0] mode, input logic [63:0] n, input logic [63:0] d,
                       output logic [63:0] q, output logic [63:0] r, output logic e);
    logic [63:0] en, ed;
    longint sn, sd;
    en = (mode == 2'd0) ? {{32{n[31]}}, n[31:0]} : n;
    ed = (mode == 2'd2) ? d : {{32{d[31]}}, d[31:0]};
    sn = en; sd = ed;
    if (sd == 0) begin
      q = (sn < 0) ? 64'd1 : 64'd0; r = en; e = 1'b1;
    end else if (en == 64'h8000_0000_0000_0000 && sd == -1) begin
      q = en; r = prev_rem; e = 1'b1;
    end else begin
      q = sn / sd; r = sn % sd; e = 1'b0;
    end
  endtask

  task automatic run_div(input string req, input logic [1:0] mode, input logic [63:0] n, input logic [63:0] d);
    logic [63:0] q, r, eq, er;
    logic [31:0] c;
    logic        e;
    bus_write(I_CTL, {30'd0, mode}, 4'hF);
    bus_write(I_NUM, n[31:0], 4'hF);
    bus_write(I_NUM + 1, n[63:32], 4'hF);
    bus_write(I_DEN, d[31:0], 4'hF);
    bus_write(I_DEN + 1, d[63:32], 4'hF);
    idle(LAT);
    model(mode, n, d, eq, er, e);
    read64(I_QUO, q);
    read64(I_REM, r);
    bus_read(I_CTL, c);
    check({req, " quotient"}, q, eq);
    check({req, " remainder"}, r, er);
    check({req, " control word"}, {32'd0, c}, {32'd0, 16'd0, 1'b0, e, 12'd0, mode});
    prev_rem = er;
  endtask

  task automatic t_reset();
    logic [31:0] c;
    logic [63:0] v;
    bus_read(I_CTL, c);
    check("R12 control after reset", {32'd0, c}, 64'd0);
    read64(I_QUO, v);
    check("R12 quotient after reset", v, 64'd0);
    read64(I_REM, v);
    check("R12 remainder after reset", v, 64'd0);
    read64(I_NUM, v);
    check("R12 dividend after reset", v, 64'd0);
  endtask

  task automatic t_signs();
    run_div("R2 pos/pos", 2'd2, 64'd1_000_000_000_007, 64'd12345);
    run_div("R2 neg/pos", 2'd2, -64'sd7, 64'd2);
    run_div("R2 pos/neg", 2'd2, 64'd7, -64'sd2);
    run_div("R2 neg/neg", 2'd2, -64'sd7, -64'sd2);
    run_div("R2 min/1", 2'd2, 64'h8000_0000_0000_0000, 64'd1);
    run_div("R2 min/min", 2'd2, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
    run_div("R2 small/min", 2'd2, 64'd5, 64'h8000_0000_0000_0000);
  endtask

  task automatic t_modes();
    run_div("R1 mode0 upper halves ignored", 2'd0, 64'h1234_5678_FFFF_FFF9, 64'hABCD_0000_0000_0002);
    run_div("R1 mode0 -2^31/-1", 2'd0, 64'h0000_0000_8000_0000, 64'h0000_0001_FFFF_FFFF);
    run_div("R1 mode1 wide num narrow den", 2'd1, 64'h0000_0123_4567_89AB, 64'h7777_0000_FFFF_FFFD);
    run_div("R1 mode3 like mode1", 2'd3, 64'hFFFF_F000_0000_0001, 64'h0000_0001_0000_0007);
    run_div("R1 mode2 wide den", 2'd2, 64'h0000_0123_4567_89AB, 64'h0000_0001_0000_0000);
  endtask

  task automatic t_zero();
    run_div("R3 zero den pos num", 2'd2, 64'd99, 64'd0);
    run_div("R3 zero den neg num", 2'd2, -64'sd99, 64'd0);
    run_div("R3 mode1 den low half zero", 2'd1, 64'd17, 64'hFFFF_0000_0000_0000);
    run_div("R5 normal clears error", 2'd2, 64'd40, 64'd6);
  endtask

  task automatic t_ovf();
    run_div("R4 setup remainder", 2'd2, 64'd23, 64'd5);
    run_div("R4 min by minus one", 2'd2, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
    run_div("R5 clears after overflow", 2'd2, 64'd9, 64'd4);
  endtask

  task automatic t_busy_restart();
    logic [31:0] c, w;
    logic [63:0] v;
    run_div("R6 setup 100/7", 2'd2, 64'd100, 64'd7);
    bus_write(I_DEN, 32'd3, 4'hF);
    idle(20);
    bus_read(I_QUO, w);
    check("R7 quotient held while busy", {32'd0, w}, 64'd14);
    bus_read(I_CTL, c);
    check("R6 busy mid-run", {63'd0, c[15]}, 64'd1);
    bus_write(I_DEN, 32'd9, 4'hF);
    idle(LAT - 1);
    bus_read(I_CTL, c);
    check("R8 busy still set at restart latency", {63'd0, c[15]}, 64'd1);
    bus_read(I_CTL, c);
    check("R6 busy clear one cycle later", {63'd0, c[15]}, 64'd0);
    read64(I_QUO, v);
    check("R8 quotient from restarted run", v, 64'd11);
    read64(I_REM, v);
    check("R8 remainder from restarted run", v, 64'd1);
    prev_rem = 64'd1;
  endtask

  task automatic t_bytes();
    logic [31:0] c, w;
    logic [63:0] v;
    run_div("R9 setup 100/10", 2'd2, 64'd100, 64'd10);
    bus_write(I_NUM, 32'hAAAA_0100, 4'b0010);
    idle(LAT);
    bus_read(I_NUM, w);
    check("R9 only lane 1 written", {32'd0, w}, 64'h164);
    read64(I_QUO, v);
    check("R9 quotient after lane write", v, 64'd35);
    read64(I_REM, v);
    check("R9 remainder after lane write", v, 64'd6);
    bus_write(I_DEN, 32'hFFFF_FFFF, 4'b0000);
    bus_read(I_CTL, c);
    check("R10 no-enable write does not start", {63'd0, c[15]}, 64'd0);
    bus_read(I_DEN, w);
    check("R10 no-enable write keeps divisor", {32'd0, w}, 64'd10);
    prev_rem = 64'd6;
  endtask

  task automatic t_readonly();
    logic [31:0] c, w;
    bus_write(I_QUO, 32'hDEAD_BEEF, 4'hF);
    bus_read(I_CTL, c);
    check("R10 result write does not start", {63'd0, c[15]}, 64'd0);
    bus_read(I_QUO, w);
    check("R10 result write ignored", {32'd0, w}, 64'd35);
    bus_write(12, 32'h1234_5678, 4'hF);
    bus_read(I_CTL, c);
    check("R10 unused write does not start", {63'd0, c[15]}, 64'd0);
    bus_read(12, w);
    check("R11 unused word reads zero", {32'd0, w}, 64'd0);
    bus_addr = ADDR_W'(I_NUM * 4 + 1); bus_wdata = 32'hFFFF_FFFF; bus_be = 4'hF; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
    bus_read(I_NUM, w);
    check("R10 misaligned write ignored", {32'd0, w}, 64'h164);
    bus_read(1, w);
    check("R11 gap word reads zero", {32'd0, w}, 64'd0);
    bus_write(I_CTL, 32'hFFFF_FFFE, 4'hF);
    idle(LAT);
    bus_read(I_CTL, c);
    check("R11 control spare bits read zero", {32'd0, c}, 64'h2);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_be = '0; bus_wdata = '0; bus_rd = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_signs();
    t_modes();
    t_zero();
    t_ovf();
    t_busy_restart();
    t_bytes();
    t_readonly();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R6: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule